// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block sits between a simple request port and an 8-bit NAND flash device. It turns one request into the full series of bus cycles the device expects. The supported requests are page read, page program, block erase, status read, ID read and device reset. Each bus cycle places a command code, an address byte or a data byte on the I/O bus, or samples one byte from it. The strobe widths are counted in clock cycles.

The block holds the bus quiet for a configurable recovery window after reset. While the device reports busy, it does no bus activity. After a program or erase, it reads the device status and reports the pass/fail bit. For reads and programs, the area pointer command is chosen from the requested column, so that spare-area bytes can be reached directly.

The host presents one request at a time. For a program, it supplies write bytes on a stream port that advances on a one-cycle take pulse. It receives read bytes on a stream port with a valid pulse, and sees a one-cycle completion pulse when the request has finished.

Top module: `nand_seq`

## Requirements
- R1: From reset until PWR_CYC clock edges have passed, ce_n and we_n stay high, wp_n stays low and req_ready stays low. req_ready first reads high after exactly PWR_CYC edges, and wp_n is high from then on.
- R2: A command cycle has cle=1, ale=0, ce_n=0 and re_n=1, and the code is on io_out when we_n rises. cle and ale are never both high.
- R3: An address cycle has ale=1 and cle=0. For read and program, the block sends the column low byte and then ROW_BYTES row bytes, least significant first. Erase sends only the row bytes. ID read sends a single 0x00.
- R4: Read and program begin with a pointer command chosen from the column: 0x00 for columns 0–255, 0x01 for 256–511 and 0x50 for 512–527.
- R5: Program (req_op=1) emits: the pointer, 0x80, the address, req_len data bytes with cle=ale=0 taken in order from wr_data (one wr_take pulse per byte), and then 0x10.
- R6: Erase (req_op=2) emits 0x60, the row bytes, then 0xD0.
- R7: Every we_n low pulse lasts WE_LO clocks. Every re_n low pulse lasts RE_LO clocks.
- R8: Page read (req_op=0) and ID read (req_op=4, preceded by command 0x90) return req_len bytes on rd_data. Each byte is the io_in value sampled RD_DLY clocks after the matching re_n fall.
- R9: After the busy-starting cycle (the last read address byte, 0x10, 0xD0 or 0xFF), the block waits BUSY_GAP clocks. It then makes no strobe and no completion until rb is high.
- R10: After program or erase, the block emits 0x70, reads one status byte to rd_data, and sets fail to bit 0 of that byte. A status request (req_op=3) emits 0x70 and returns one byte with fail=0.
- R11: Reset (req_op=5) emits 0xFF, waits for ready as in R9, then pulses done with no further cycles.
- R12: we_n and re_n are never low together. io_oe is high exactly while a write-type cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_op | input | 3 | Operation code |
| req_row | input | 8*ROW_BYTES | Row (page) address |
| req_col | input | 10 | Column address |
| req_len | input | LW | Data byte count (1 or more) |
| wr_data | input | 8 | Program data byte |
| wr_take | output | 1 | Current write byte consumed |
| rd_data | output | 8 | Byte read from device |
| rd_valid | output | 1 | rd_data valid pulse |
| done | output | 1 | Request complete pulse |
| fail | output | 1 | Status bit 0 of last program/erase |
| io_out | output | 8 | Bus drive value |
| io_in | input | 8 | Bus input value |
| io_oe | output | 1 | Bus output enable |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write enable, active low |
| re_n | output | 1 | Read enable, active low |
| wp_n | output | 1 | Write protect, active low |
| rb | input | 1 | Ready (1) / busy (0) |

## Verification
A wrong sequencer state shows up at the very next we_n rise. It appears as a logged cycle whose cle/ale flags or byte differ from the list the bench computes for that request, and any missing or extra cycle changes the log length at completion. A wrong byte counter shifts the address or data bytes, or produces a wrong number of read bytes, and this is visible within one request. A timer fault changes the measured strobe widths on the first pulse, and a busy-wait fault produces a strobe while rb is low.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int ROW_BYTES = 2,
  parameter int WE_LO     = 2,
  parameter int WE_HI     = 2,
  parameter int RE_LO     = 2,
  parameter int RE_HI     = 2,
  parameter int RD_DLY    = 2,
  parameter int BUSY_GAP  = 4,
  parameter int PWR_CYC   = 1000,
  parameter int LW        = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [2:0]             req_op,
  input  logic [8*ROW_BYTES-1:0] req_row,
  input  logic [9:0]             req_col,
  input  logic [LW-1:0]          req_len,
  input  logic [7:0]             wr_data,
  output logic                   wr_take,
  output logic [7:0]             rd_data,
  output logic                   rd_valid,
  output logic                   done,
  output logic                   fail,
  output logic [7:0]             io_out,
  input  logic [7:0]             io_in,
  output logic                   io_oe,
  output logic                   ce_n,
  output logic                   cle,
  output logic                   ale,
  output logic                   we_n,
  output logic                   re_n,
  output logic                   wp_n,
  input  logic                   rb
);
  localparam int TW = $clog2(PWR_CYC + 64);
  localparam logic [2:0] OP_RD = 3'd0, OP_PG = 3'd1, OP_ER = 3'd2,
                         OP_ST = 3'd3, OP_ID = 3'd4, OP_RS = 3'd5;

  typedef enum logic [3:0] {
    S_PWR, S_IDLE, S_PTR, S_CMD1, S_ADDR, S_WDAT, S_CMD2,
    S_WAITB, S_RDAT, S_STC, S_STR, S_DONE
  } st_t;

  st_t st, nst;
  logic [2:0]             op;
  logic [8*ROW_BYTES-1:0] row;
  logic [9:0]             col;
  logic [LW-1:0]          len, cnt, nad, rsel;
  logic [TW-1:0]          tmr, lo_n, hi_n;
  logic                   ph;
  logic [7:0]             rbyte;

  wire wcyc = st inside {S_PTR, S_CMD1, S_ADDR, S_WDAT, S_CMD2, S_STC};
  wire rcyc = st inside {S_RDAT, S_STR};
  assign lo_n = wcyc ? TW'(WE_LO) : TW'(RE_LO);
  assign hi_n = wcyc ? TW'(WE_HI) : TW'(RE_HI);
  wire cyc_end   = (wcyc | rcyc) & ph & (tmr == hi_n - 1'b1);
  assign nad = (op == OP_ER) ? LW'(ROW_BYTES) : (op == OP_ID) ? LW'(1) : LW'(ROW_BYTES + 1);
  wire last_addr = (cnt == nad - 1'b1);
  wire last_dat  = (cnt == len - 1'b1);

  always_comb begin
    nst = st;
    case (st)
      S_PWR:   if (tmr == TW'(PWR_CYC - 1)) nst = S_IDLE;
      S_IDLE:  if (req_valid)
                 case (req_op)
                   OP_RD, OP_PG:        nst = S_PTR;
                   OP_ST:               nst = S_STC;
                   OP_ER, OP_ID, OP_RS: nst = S_CMD1;
                   default:             nst = S_IDLE;
                 endcase
      S_PTR:   if (cyc_end) nst = (op == OP_PG) ? S_CMD1 : S_ADDR;
      S_CMD1:  if (cyc_end) nst = (op == OP_RS) ? S_WAITB : S_ADDR;
      S_ADDR:  if (cyc_end && last_addr)
                 case (op)
                   OP_RD:   nst = S_WAITB;
                   OP_PG:   nst = S_WDAT;
                   OP_ER:   nst = S_CMD2;
                   default: nst = S_RDAT;
                 endcase
      S_WDAT:  if (cyc_end && last_dat) nst = S_CMD2;
      S_CMD2:  if (cyc_end) nst = S_WAITB;
      S_WAITB: if (ph && rb)
                 nst = (op == OP_RD) ? S_RDAT : (op == OP_RS) ? S_DONE : S_STC;
      S_RDAT:  if (cyc_end && last_dat) nst = S_DONE;
      S_STC:   if (cyc_end) nst = S_STR;
      S_STR:   if (cyc_end) nst = S_DONE;
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PWR; ph <= 1'b0; tmr <= '0; cnt <= '0;
      op <= '0; row <= '0; col <= '0; len <= '0;
      rd_data <= '0; rd_valid <= 1'b0; fail <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (st != nst) begin
        st <= nst; ph <= 1'b0; tmr <= '0; cnt <= '0;
      end else if (wcyc | rcyc) begin
        if (!ph) begin
          if (tmr == lo_n - 1'b1) begin ph <= 1'b1; tmr <= '0; end
          else tmr <= tmr + 1'b1;
        end else if (tmr == hi_n - 1'b1) begin
          ph <= 1'b0; tmr <= '0; cnt <= cnt + 1'b1;
        end else tmr <= tmr + 1'b1;
      end else if (st == S_WAITB) begin
        if (!ph) begin
          if (tmr == TW'(BUSY_GAP - 1)) ph <= 1'b1;
          else tmr <= tmr + 1'b1;
        end
      end else if (st == S_PWR) tmr <= tmr + 1'b1;

      if (rcyc && !ph && tmr == TW'(RD_DLY - 1)) begin
        rd_data  <= io_in;
        rd_valid <= 1'b1;
        if (st == S_STR) fail <= io_in[0] & (op == OP_PG || op == OP_ER);
      end
      if (st == S_IDLE && req_valid) begin
        op <= req_op; row <= req_row; col <= req_col; len <= req_len; fail <= 1'b0;
      end
    end
  end

  always_comb begin
    rsel  = (op == OP_ER) ? cnt : cnt - 1'b1;
    rbyte = '0;
    for (int k = 0; k < ROW_BYTES; k++)
      if (rsel == LW'(k)) rbyte = row[8*k +: 8];
    case (st)
      S_PTR:   io_out = (col < 10'd256) ? 8'h00 : (col < 10'd512) ? 8'h01 : 8'h50;
      S_CMD1:  io_out = (op == OP_PG) ? 8'h80 : (op == OP_ER) ? 8'h60 :
                        (op == OP_ID) ? 8'h90 : 8'hFF;
      S_CMD2:  io_out = (op == OP_PG) ? 8'h10 : 8'hD0;
      S_STC:   io_out = 8'h70;
      S_ADDR:  io_out = (op == OP_ID) ? 8'h00 :
                        (op != OP_ER && cnt == '0) ? col[7:0] : rbyte;
      S_WDAT:  io_out = wr_data;
      default: io_out = 8'h00;
    endcase
  end

  assign ce_n      = st inside {S_PWR, S_IDLE};
  assign cle       = st inside {S_PTR, S_CMD1, S_CMD2, S_STC};
  assign ale       = (st == S_ADDR);
  assign we_n      = !(wcyc && !ph);
  assign re_n      = !(rcyc && !ph);
  assign io_oe     = wcyc;
  assign wp_n      = (st != S_PWR);
  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_DONE);
  assign wr_take   = (st == S_WDAT) && cyc_end;

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
  // R2
  cle_ale_chk: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  // R1
  pwr_pins_chk: assert property (@(posedge clk) disable iff (!rst_n) !wp_n |-> (ce_n && we_n && !req_ready));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITB && !rb) |=> (st == S_WAITB && we_n && re_n));
  // R8
  rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(!re_n));
  // R2
  cmd_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) cle |-> (!ce_n && re_n && io_oe));
endmodule

// File: tb/nand_seq_tb.sv
module nand_seq_tb_top;
  localparam int RB = 3, WLO = 2, WHI = 3, RLO = 3, RHI = 2, RDD = 2, GAP = 3, PWR = 40, LW = 10;
  localparam int BUSY_T = 20;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_ready, wr_take, rd_valid, done, fail;
  logic [2:0] req_op = 0;
  logic [8*RB-1:0] req_row = 0;
  logic [9:0] req_col = 0;
  logic [LW-1:0] req_len = 1;
  logic [7:0] wr_data, rd_data, io_out, io_in = 0;
  logic io_oe, ce_n, cle, ale, we_n, re_n, wp_n, rb = 1;

  int errs = 0, checks = 0, wi = 0;

  function automatic logic [7:0] pat(int k); return 8'(k*13 + 90); endfunction
  function automatic logic [7:0] wdat(int k); return 8'(k*29 + 17); endfunction
  assign wr_data = wdat(wi);

  nand_seq #(.ROW_BYTES(RB), .WE_LO(WLO), .WE_HI(WHI), .RE_LO(RLO), .RE_HI(RHI),
             .RD_DLY(RDD), .BUSY_GAP(GAP), .PWR_CYC(PWR), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_row(req_row), .req_col(req_col), .req_len(req_len), .wr_data(wr_data),
    .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .fail(fail),
    .io_out(io_out), .io_in(io_in), .io_oe(io_oe), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .rb(rb));

  logic [9:0] wlog [0:700];
  logic [9:0] ew   [0:700];
  logic [7:0] rbuf [0:700];
  int wn = 0, en = 0, rn = 0;
  int wl = 0, rl = 0, width_err = 0, excl_err = 0, busy_err = 0, oe_err = 0;
  int rd_idx = 0, addr_seen = 0, bcnt = 0;
  logic [7:0] last_cmd = 0, status_val = 0;
  logic [2:0] cur_op = 0;
  logic p_we = 1, p_re = 1, p_cle = 0, p_ale = 0;
  logic [7:0] p_io = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n && !re_n) excl_err++;
      if (io_oe && !re_n) oe_err++;
      if (!rb && ((p_we && !we_n) || (p_re && !re_n) || done)) busy_err++;
      if (bcnt > 0) begin bcnt--; if (bcnt == 0) rb = 1; end
      if (!we_n) wl++;
      if (!p_we && we_n) begin
        if (wl != WLO) width_err++;
        wl = 0;
        wlog[wn] = {p_cle, p_ale, p_io}; wn++;
        if (p_cle) begin
          last_cmd = p_io; rd_idx = 0; addr_seen = 0;
          if (p_io == 8'h10 || p_io == 8'hD0 || p_io == 8'hFF) begin rb = 0; bcnt = BUSY_T; end
        end
        if (p_ale) begin
          rd_idx = 0; addr_seen++;
          if (cur_op == 0 && addr_seen == 1 + RB) begin rb = 0; bcnt = BUSY_T; end
        end
      end
      if (!re_n) rl++;
      if (!p_re && re_n) begin if (rl != RLO) width_err++; rl = 0; end
      if (p_re && !re_n) begin
        io_in = (last_cmd == 8'h70) ? status_val : pat(rd_idx);
        rd_idx++;
      end
      if (rd_valid) begin rbuf[rn] = rd_data; rn++; end
      if (wr_take) wi++;
      p_we = we_n; p_re = re_n; p_cle = cle; p_ale = ale; p_io = io_out;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic add(input bit c, input bit a, input logic [7:0] b);
    ew[en] = {c, a, b}; en++;
  endtask

  task automatic run(input logic [2:0] op, input logic [8*RB-1:0] row, input logic [9:0] col,
                     input int len, input logic [7:0] st, input string tag);
    logic [7:0] ptr;
    bit fv, ok;
    int nr;
    wn = 0; rn = 0; wi = 0; en = 0; width_err = 0; excl_err = 0; busy_err = 0; oe_err = 0;
    cur_op = op; status_val = st;
    while (!req_ready) @(negedge clk);
    req_op = op; req_row = row; req_col = col; req_len = LW'(len); req_valid = 1;
    @(negedge clk); req_valid = 0;
    while (!done) @(negedge clk);
    fv = fail;
    repeat (3) @(negedge clk);
    ptr = (col < 256) ? 8'h00 : (col < 512) ? 8'h01 : 8'h50;
    case (op)
      3'd0: begin add(1,0,ptr); add(0,1,col[7:0]); for (int k=0;k<RB;k++) add(0,1,row[8*k+:8]); end
      3'd1: begin add(1,0,ptr); add(1,0,8'h80); add(0,1,col[7:0]);
                  for (int k=0;k<RB;k++) add(0,1,row[8*k+:8]);
                  for (int k=0;k<len;k++) add(0,0,wdat(k)); add(1,0,8'h10); add(1,0,8'h70); end
      3'd2: begin add(1,0,8'h60); for (int k=0;k<RB;k++) add(0,1,row[8*k+:8]);
                  add(1,0,8'hD0); add(1,0,8'h70); end
      3'd3: add(1,0,8'h70);
      3'd4: begin add(1,0,8'h90); add(0,1,8'h00); end
      default: add(1,0,8'hFF);
    endcase
    ok = (wn == en);
    for (int k = 0; k < en && k < wn; k++) if (wlog[k] != ew[k]) ok = 0;
    chk(ok, {tag, " bus cycle list (R2 R3 R4 R5 R6 R11)"}, wn, en);
    nr = (op == 3'd0 || op == 3'd4) ? len : (op == 3'd5) ? 0 : 1;
    ok = (rn == nr);
    for (int k = 0; k < nr && k < rn; k++)
      if (rbuf[k] != ((op == 3'd0 || op == 3'd4) ? pat(k) : st)) ok = 0;
    chk(ok, {tag, " read bytes (R8 R10)"}, rn, nr);
    chk(fv == ((op == 3'd1 || op == 3'd2) ? st[0] : 1'b0), {tag, " fail flag R10"}, fv,
        (op == 3'd1 || op == 3'd2) ? st[0] : 0);
    chk(width_err == 0, {tag, " strobe widths R7"}, width_err, 0);
    chk(excl_err == 0 && oe_err == 0, {tag, " strobe exclusion R12"}, excl_err + oe_err, 0);
    chk(busy_err == 0 && rb, {tag, " busy wait R9"}, busy_err, 0);
    if (op == 3'd1) chk(wi == len, {tag, " write takes R5"}, wi, len);
  endtask

  initial begin
    bit bad;
    int cols [6] = '{0, 255, 256, 511, 512, 527};
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && !wp_n && !req_ready, "reset pins R1", {ce_n, we_n, wp_n, req_ready}, 4'b1100);
    rst_n = 1;
    bad = 0;
    for (int k = 1; k < PWR; k++) begin
      @(negedge clk);
      if (req_ready || !ce_n || !we_n || wp_n) bad = 1;
    end
    chk(!bad, "power-up hold R1", bad, 0);
    @(negedge clk);
    chk(req_ready && wp_n, "power-up end R1", {req_ready, wp_n}, 2'b11);

    foreach (cols[i]) run(3'd0, 24'h123456 + 24'(i*4097), cols[i], 1 + i % 4, 8'h00, "read");
    for (int c = 0; c < 528; c += 131) run(3'd0, 24'hA0B0C0, 10'(c), 2, 8'h00, "read sweep");
    run(3'd1, 24'h010203, 10'd0,   5, 8'h01, "prog lo");
    run(3'd1, 24'h0F0E0D, 10'd300, 3, 8'hC0, "prog hi");
    run(3'd1, 24'h777777, 10'd520, 2, 8'hE1, "prog spare");
    run(3'd2, 24'hABCDE0, 10'd0,   1, 8'h01, "erase fail");
    run(3'd2, 24'h000020, 10'd0,   1, 8'hE0, "erase pass");
    run(3'd3, 24'h0,      10'd0,   1, 8'h5C, "status");
    run(3'd4, 24'h0,      10'd0,   4, 8'h00, "id");
    run(3'd5, 24'h0,      10'd0,   1, 8'h00, "reset");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule